// File: doc/BRIEF.md
# Polled Single-Select SPI Master

This block is a serial peripheral master sitting behind a small word-wide register bus. Software sets up clock rate, word length and clock mode in a configuration word, raises the only chip select through a control bit, and then moves data one word at a time: each write to the transmit location launches one full-duplex exchange of 8 or 16 bits. While the word is on the wire a busy bit is visible; when it has finished, a done bit is raised, and the word clocked in from the slave can be read from the receive location.

The serial clock comes from the core clock through a counter. The low nibble of the prescale field gives the half period in core cycles, so the serial clock runs at the core clock divided by twice that value. Software is expected to clear the done bit by writing zero to the cause location before each word and to poll it afterwards. The chip select does not change while words move. It changes only when software rewrites the control location, so several words can share one select window.

Register offsets: 0x00 control, 0x04 configuration, 0x08 transmit data, 0x0C receive data, 0x10 cause. Reads are combinational on the address and have no side effects.

Top module: `spi_regmaster`

## Requirements
- R1: After reset the control location (0x00) reads 0, configuration (0x04) reads 0x12, cause (0x10) reads 0, receive (0x0C) reads 0, the chip select output is high (released) and the serial clock is low.
- R2: Control bit 0 set drives the active-low chip select low, and clearing it releases the select. The select level does not change during or between words unless control is rewritten.
- R3: Configuration bits 3:0 give the serial clock half period in core cycles, and values 0 and 1 act as 2. A word of W bits keeps cause bit 1 set for exactly 2*W*half core cycles after the transmit write. Configuration bit 4 is stored but has no effect on the rate.
- R4: Configuration bit 5 selects the word length: 0 gives 8 bits taken from write data bits 7:0, and 1 gives 16 bits taken from bits 15:0. A word produces exactly 2*W serial clock edges.
- R5: Configuration bit 11 is the idle level of the serial clock. With configuration bit 12 at 0, both sides sample on the first edge of each bit, and with it at 1 they sample on the second edge. Data goes most significant bit first on both data lines.
- R6: A write to the transmit location (0x08) while idle starts a word. Cause bit 1 reads 1 while the word runs, and at its end cause reads 1 (bit 0 done set, bit 1 clear).
- R7: A write to cause clears bit 0 when write data bit 0 is 0 and leaves it set when write data bit 0 is 1.
- R8: A write to the transmit location while a word runs is ignored: the word on the wire and its length are unchanged.
- R9: Word length, clock mode and half period are captured when a word starts. A configuration write during a word affects only later words.
- R10: The receive location returns the last received word zero-extended to 32 bits, and it holds that word until the next word completes.
- R11: Configuration reads back only bits 12, 11, 5 and 4:0, with all other bits zero. Control reads back only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per register write |
| bus_addr_i | input | ADDR_W (5) | Byte offset of the addressed register |
| bus_wdata_i | input | BUS_W (32) | Write data |
| bus_rdata_o | output | BUS_W (32) | Read data for the addressed register |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the slave |
| spi_miso_i | input | 1 | Serial data from the slave |
| spi_cs_no | output | 1 | Chip select, active low |

## Verification
A miscounted divider or edge counter shows at once as a wrong busy length, a wrong edge count or a serial clock that does not rest at its idle level after the word. A wrong sample or launch phase corrupts the slave's captured word or the receive location, and this shows when the first word in that mode completes. Errors in done or receive handling show on the first cause or receive read after the word, and errors in capturing the configuration at start show only when configuration is rewritten mid-word. For that reason the bench provokes those mid-word writes on purpose.

// File: rtl/spi_rm_pkg.sv
`timescale 1ns/1ps
package spi_rm_pkg;
   // Register byte offsets
   localparam logic [4:0] OFS_CTRL  = 5'h00;
   localparam logic [4:0] OFS_CFG   = 5'h04;
   localparam logic [4:0] OFS_TXD   = 5'h08;
   localparam logic [4:0] OFS_RXD   = 5'h0C;
   localparam logic [4:0] OFS_CAUSE = 5'h10;

   // Configuration field positions
   localparam int unsigned PRESC_W    = 5;
   localparam int unsigned CFG_WIDE_B = 5;
   localparam int unsigned CFG_CPOL_B = 11;
   localparam int unsigned CFG_CPHA_B = 12;

   typedef struct packed {
      logic               cpha;
      logic               cpol;
      logic               wide;
      logic [PRESC_W-1:0] presc;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{cpha: 1'b0, cpol: 1'b0, wide: 1'b0, presc: 5'h12};
endpackage

// File: rtl/spi_rm_regs.sv
`timescale 1ns/1ps
module spi_rm_regs
   import spi_rm_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned WIDE_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   input  logic              busy_i,
   input  logic              fin_i,
   input  logic [WIDE_W-1:0] rx_word_i,
   output logic              cs_en_o,
   output cfg_t              cfg_o,
   output logic              start_o,
   output logic [WIDE_W-1:0] tx_word_o,
   output logic              done_o,
   output logic [WIDE_W-1:0] rx_hold_o,
   output logic [BUS_W-1:0]  rdata_o
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_TXD   = ADDR_W'(OFS_TXD);
   localparam logic [ADDR_W-1:0] A_RXD   = ADDR_W'(OFS_RXD);
   localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);

   logic              hit_ctrl, hit_cfg, hit_txd, hit_cause;
   logic              cs_en_q, done_q;
   cfg_t              cfg_q;
   logic [WIDE_W-1:0] rx_q;
   logic              unused_wdata_hi;

   assign hit_ctrl  = wr_i && (addr_i == A_CTRL);
   assign hit_cfg   = wr_i && (addr_i == A_CFG);
   assign hit_txd   = wr_i && (addr_i == A_TXD);
   assign hit_cause = wr_i && (addr_i == A_CAUSE);

   assign unused_wdata_hi = ^wdata_i[BUS_W-1:WIDE_W];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_en_q <= 1'b0;
         cfg_q   <= CFG_RESET;
      end else begin
         if (hit_ctrl) cs_en_q <= wdata_i[0];
         if (hit_cfg) begin
            cfg_q.presc <= wdata_i[PRESC_W-1:0];
            cfg_q.wide  <= wdata_i[CFG_WIDE_B];
            cfg_q.cpol  <= wdata_i[CFG_CPOL_B];
            cfg_q.cpha  <= wdata_i[CFG_CPHA_B];
         end
      end
   end

   // Completion has priority over a simultaneous clearing write.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         done_q <= 1'b0;
         rx_q   <= '0;
      end else begin
         if (fin_i)          done_q <= 1'b1;
         else if (hit_cause) done_q <= done_q & wdata_i[0];
         if (fin_i) rx_q <= rx_word_i;
      end
   end

   assign start_o   = hit_txd && !busy_i;
   assign tx_word_o = wdata_i[WIDE_W-1:0];
   assign cs_en_o   = cs_en_q;
   assign cfg_o     = cfg_q;
   assign done_o    = done_q;
   assign rx_hold_o = rx_q;

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         A_CTRL:  rdata_o[0] = cs_en_q;
         A_CFG: begin
            rdata_o[PRESC_W-1:0] = cfg_q.presc;
            rdata_o[CFG_WIDE_B]  = cfg_q.wide;
            rdata_o[CFG_CPOL_B]  = cfg_q.cpol;
            rdata_o[CFG_CPHA_B]  = cfg_q.cpha;
         end
         A_RXD:   rdata_o[WIDE_W-1:0] = rx_q;
         A_CAUSE: rdata_o[1:0] = {busy_i, done_q};
         default: rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/spi_rm_tick.sv
`timescale 1ns/1ps
module spi_rm_tick #(
   parameter int unsigned NIB_W    = 4,
   parameter int unsigned MIN_HALF = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             run_i,
   input  logic [NIB_W-1:0] nib_i,
   output logic             tick_o
);
   localparam logic [NIB_W-1:0] HALF_FLOOR = NIB_W'(MIN_HALF);

   logic [NIB_W-1:0] half_q, cnt_q, half_eff;

   assign half_eff = (nib_i < HALF_FLOOR) ? HALF_FLOOR : nib_i;
   assign tick_o   = run_i && (cnt_q == (half_q - 1'b1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         half_q <= HALF_FLOOR;
         cnt_q  <= '0;
      end else if (start_i) begin
         half_q <= half_eff;
         cnt_q  <= '0;
      end else if (tick_o) begin
         cnt_q  <= '0;
      end else if (run_i) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/spi_rm_shift.sv
`timescale 1ns/1ps
module spi_rm_shift #(
   parameter int unsigned WIDE_W    = 16,
   parameter int unsigned NARROW_W  = 8,
   parameter int unsigned MISO_SYNC = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [WIDE_W-1:0] tx_word_i,
   input  logic              wide_i,
   input  logic              cpol_i,
   input  logic              cpha_i,
   input  logic              tick_i,
   input  logic              miso_i,
   output logic              busy_o,
   output logic              fin_o,
   output logic              sck_o,
   output logic              mosi_o,
   output logic [WIDE_W-1:0] rx_word_o
);
   localparam int unsigned EDGE_W = $clog2(2 * WIDE_W);
   localparam int unsigned PAD    = WIDE_W - NARROW_W;
   localparam logic [EDGE_W-1:0] LAST_WIDE   = EDGE_W'(2 * WIDE_W - 1);
   localparam logic [EDGE_W-1:0] LAST_NARROW = EDGE_W'(2 * NARROW_W - 1);

   logic miso_s;

   generate
      if (MISO_SYNC != 0) begin : g_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) sync_q <= '0;
            else         sync_q <= {sync_q[0], miso_i};
         end
         assign miso_s = sync_q[1];
      end else begin : g_direct
         assign miso_s = miso_i;
      end
   endgenerate

   logic              busy_q, wide_q, cpha_q, sck_q;
   logic [EDGE_W-1:0] edge_q;
   logic [WIDE_W-1:0] tx_sr, rx_sr, rx_next, rx_fin, tx_load;
   logic              last_edge, leading, samp_edge, launch_edge;

   assign last_edge   = (edge_q == (wide_q ? LAST_WIDE : LAST_NARROW));
   assign leading     = ~edge_q[0];
   assign samp_edge   = leading ^ cpha_q;
   assign launch_edge = ~samp_edge;
   assign rx_next     = {rx_sr[WIDE_W-2:0], miso_s};
   assign rx_fin      = samp_edge ? rx_next : rx_sr;
   assign tx_load     = wide_i ? tx_word_i : {tx_word_i[NARROW_W-1:0], {PAD{1'b0}}};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         wide_q <= 1'b0;
         cpha_q <= 1'b0;
         sck_q  <= 1'b0;
         edge_q <= '0;
         tx_sr  <= '0;
         rx_sr  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         wide_q <= wide_i;
         cpha_q <= cpha_i;
         sck_q  <= cpol_i;
         edge_q <= '0;
         tx_sr  <= tx_load;
         rx_sr  <= '0;
      end else if (tick_i) begin
         sck_q  <= ~sck_q;
         edge_q <= edge_q + 1'b1;
         if (launch_edge && (edge_q != '0)) tx_sr <= {tx_sr[WIDE_W-2:0], 1'b0};
         if (samp_edge) rx_sr <= rx_next;
         if (last_edge) busy_q <= 1'b0;
      end
   end

   assign busy_o    = busy_q;
   assign fin_o     = tick_i && last_edge;
   assign sck_o     = busy_q ? sck_q : cpol_i;
   assign mosi_o    = tx_sr[WIDE_W-1];
   assign rx_word_o = wide_q ? rx_fin : {{PAD{1'b0}}, rx_fin[NARROW_W-1:0]};
endmodule

// File: rtl/spi_regmaster.sv
`timescale 1ns/1ps
module spi_regmaster
   import spi_rm_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned BUS_W     = 32,
   parameter int unsigned WIDE_W    = 16,
   parameter int unsigned NARROW_W  = 8,
   parameter int unsigned MISO_SYNC = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [BUS_W-1:0]  bus_wdata_i,
   output logic [BUS_W-1:0]  bus_rdata_o,
   output logic              spi_sck_o,
   output logic              spi_mosi_o,
   input  logic              spi_miso_i,
   output logic              spi_cs_no
);
   localparam int unsigned NIB_W = PRESC_W - 1;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must cover offset 0x10");
      end
      if (WIDE_W <= NARROW_W || NARROW_W < 2) begin : g_bad_width
         $error("WIDE_W must exceed NARROW_W, NARROW_W at least 2");
      end
      if (BUS_W <= WIDE_W || BUS_W <= CFG_CPHA_B) begin : g_bad_bus
         $error("BUS_W too narrow for data or configuration fields");
      end
   endgenerate

   cfg_t              cfg_w;
   logic              cs_en_w, start_w, busy_w, fin_w, tick_w, done_w, cpol_w;
   logic [WIDE_W-1:0] tx_word_w, rx_word_w, rx_hold_w;
   logic              unused_presc_top;

   assign cpol_w           = cfg_w.cpol;
   assign unused_presc_top = cfg_w.presc[PRESC_W-1];

   spi_rm_regs #(
      .ADDR_W (ADDR_W),
      .BUS_W  (BUS_W),
      .WIDE_W (WIDE_W)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (bus_wr_i),
      .addr_i    (bus_addr_i),
      .wdata_i   (bus_wdata_i),
      .busy_i    (busy_w),
      .fin_i     (fin_w),
      .rx_word_i (rx_word_w),
      .cs_en_o   (cs_en_w),
      .cfg_o     (cfg_w),
      .start_o   (start_w),
      .tx_word_o (tx_word_w),
      .done_o    (done_w),
      .rx_hold_o (rx_hold_w),
      .rdata_o   (bus_rdata_o)
   );

   spi_rm_tick #(
      .NIB_W    (NIB_W),
      .MIN_HALF (2)
   ) u_tick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_w),
      .run_i   (busy_w),
      .nib_i   (cfg_w.presc[NIB_W-1:0]),
      .tick_o  (tick_w)
   );

   spi_rm_shift #(
      .WIDE_W    (WIDE_W),
      .NARROW_W  (NARROW_W),
      .MISO_SYNC (MISO_SYNC)
   ) u_shift (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_w),
      .tx_word_i (tx_word_w),
      .wide_i    (cfg_w.wide),
      .cpol_i    (cfg_w.cpol),
      .cpha_i    (cfg_w.cpha),
      .tick_i    (tick_w),
      .miso_i    (spi_miso_i),
      .busy_o    (busy_w),
      .fin_o     (fin_w),
      .sck_o     (spi_sck_o),
      .mosi_o    (spi_mosi_o),
      .rx_word_o (rx_word_w)
   );

   assign spi_cs_no = ~cs_en_w;
endmodule

// File: rtl/spi_regmaster_chk.sv
`timescale 1ns/1ps
module spi_regmaster_chk
   import spi_rm_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned WIDE_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bus_wr_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [BUS_W-1:0]  bus_wdata_i,
   input logic              spi_sck_o,
   input logic              spi_cs_no,
   input logic              busy_w,
   input logic              done_w,
   input logic              cpol_w,
   input logic [WIDE_W-1:0] rx_hold_w
);
   localparam logic [ADDR_W-1:0] C_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] C_TXD   = ADDR_W'(OFS_TXD);
   localparam logic [ADDR_W-1:0] C_CAUSE = ADDR_W'(OFS_CAUSE);

   logic unused_chk_wdata;
   assign unused_chk_wdata = ^bus_wdata_i[BUS_W-1:1];

   AST_CS_ONLY_BY_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_wr_i && bus_addr_i == C_CTRL) |=> $stable(spi_cs_no)); // R2

   AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_w |-> (spi_sck_o == cpol_w)); // R5

   AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == C_TXD && !busy_w) |=> busy_w); // R6

   AST_END_RAISES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_w) |-> done_w); // R6

   AST_ZERO_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == C_CAUSE && !bus_wdata_i[0] && !busy_w) |=> !done_w); // R7

   AST_RX_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(rx_hold_w) |-> $fell(busy_w)); // R10
endmodule

bind spi_regmaster spi_regmaster_chk #(
   .ADDR_W (ADDR_W),
   .BUS_W  (BUS_W),
   .WIDE_W (WIDE_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .spi_sck_o   (spi_sck_o),
   .spi_cs_no   (spi_cs_no),
   .busy_w      (busy_w),
   .done_w      (done_w),
   .cpol_w      (cpol_w),
   .rx_hold_w   (rx_hold_w)
);

// File: tb/spi_regmaster_tb.sv
`timescale 1ns/1ps
module spi_regmaster_tb_top;
   localparam logic [4:0] A_CTRL  = 5'h00;
   localparam logic [4:0] A_CFG   = 5'h04;
   localparam logic [4:0] A_TXD   = 5'h08;
   localparam logic [4:0] A_RXD   = 5'h0C;
   localparam logic [4:0] A_CAUSE = 5'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sck, mosi, cs_n;
   logic        miso = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 0;

   int b_nib = 2;
   bit b_wide = 0, b_cpol = 0, b_cpha = 0, b_cs = 0;

   always #2.5 clk = ~clk;

   spi_regmaster dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .spi_sck_o   (sck),
      .spi_mosi_o  (mosi),
      .spi_miso_i  (miso),
      .spi_cs_no   (cs_n)
   );

   function automatic int half_of(input int nib);
      return (nib < 2) ? 2 : nib;
   endfunction

   function automatic logic [31:0] cfg_word(input int nib, input bit wide, input bit cpol, input bit cpha);
      return 32'h10 | (32'(nib) & 32'hF) | (32'(wide) << 5) | (32'(cpol) << 11) | (32'(cpha) << 12);
   endfunction

   function automatic logic [31:0] word_mask(input logic [15:0] v, input bit wide);
      return wide ? {16'h0, v} : {24'h0, v[7:0]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_cfg(input int nib, input bit wide, input bit cpol, input bit cpha);
      b_nib = nib; b_wide = wide; b_cpol = cpol; b_cpha = cpha;
      wr_reg(A_CFG, cfg_word(nib, wide, cpol, cpha));
   endtask

   task automatic set_cs(input bit on);
      b_cs = on;
      wr_reg(A_CTRL, {31'h0, on});
   endtask

   // One word with a slave model; optional bus write injected mid-word.
   task automatic do_word(input logic [15:0] tx, input logic [15:0] slv,
                          input bit poke, input logic [4:0] pa, input logic [31:0] pd,
                          output logic [15:0] o_cap, output int o_busy, output int o_edges);
      logic [31:0] rv;
      logic [15:0] s_sr, cap;
      int  e, bcnt, w, half;
      logic prev;
      bit  samp, busy;
      w = b_wide ? 16 : 8;
      half = half_of(b_nib);
      wr_reg(A_CAUSE, 32'h0);
      s_sr = b_wide ? slv : {slv[7:0], 8'h00};
      cap = '0; e = 0; bcnt = 0;
      @(negedge clk);
      miso = b_cpha ? 1'b0 : s_sr[15];
      bus_wr = 1'b1; bus_addr = A_TXD; bus_wdata = {16'hDEAD, tx};
      prev = b_cpol;
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         bus_wr = 1'b0; bus_addr = A_CAUSE;
         #1;
         if (sck !== prev) begin
            samp = ((e % 2) == 0) ^ b_cpha;
            if (samp) cap = {cap[14:0], mosi};
            else if (b_cpha && e == 0) miso = s_sr[15];
            else begin
               s_sr = {s_sr[14:0], 1'b0};
               miso = s_sr[15];
            end
            e++;
            prev = sck;
         end
         busy = bus_rdata[1];
         if (!busy) break;
         bcnt++;
         if (poke && k == 3) begin
            bus_wr = 1'b1; bus_addr = pa; bus_wdata = pd;
         end
      end
      o_cap = cap; o_busy = bcnt; o_edges = e;
      chk("R4 serial edge count", e, 2 * w);
      chk("R3 busy length", bcnt, 2 * w * half);
      chk("R5 slave captured word", word_mask(cap, b_wide), word_mask(tx, b_wide));
      rd_reg(A_CAUSE, rv);
      chk("R6 cause after word", rv, 32'h1);
      rd_reg(A_RXD, rv);
      chk("R10 received word", rv, word_mask(slv, b_wide));
      chk("R5 idle clock level", {31'h0, sck}, {31'h0, b_cpol});
      chk("R2 select level", {31'h0, cs_n}, {31'h0, !b_cs});
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      if (!done_flag) begin
         n_chk++; n_fail++;
         $display("FAIL R6 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rv, keep;
      logic [15:0] cap, tx, slv;
      int bc, ed;
      void'($urandom(32'd51877));

      repeat (3) @(negedge clk);
      chk("R1 select released in reset", {31'h0, cs_n}, 32'h1);
      chk("R1 clock low in reset", {31'h0, sck}, 32'h0);
      rst_n = 1'b1;
      rd_reg(A_CTRL, rv);  chk("R1 control reset", rv, 32'h0);
      rd_reg(A_CFG, rv);   chk("R1 config reset", rv, 32'h12);
      rd_reg(A_CAUSE, rv); chk("R1 cause reset", rv, 32'h0);
      rd_reg(A_RXD, rv);   chk("R1 receive reset", rv, 32'h0);

      // R11 readback masks
      wr_reg(A_CFG, 32'hFFFF_FFFF);
      rd_reg(A_CFG, rv);  chk("R11 config readback", rv, 32'h0000_183F);
      wr_reg(A_CTRL, 32'hFFFF_FFFE);
      rd_reg(A_CTRL, rv); chk("R11 control readback", rv, 32'h0);
      chk("R2 select stays released", {31'h0, cs_n}, 32'h1);

      set_cfg(2, 0, 0, 0);
      set_cs(1);
      chk("R2 select asserted", {31'h0, cs_n}, 32'h0);

      // Directed words in each mode
      do_word(16'h00A5, 16'h003C, 0, A_TXD, 0, cap, bc, ed);
      set_cfg(3, 1, 1, 1);
      do_word(16'hB3C1, 16'h5E0F, 0, A_TXD, 0, cap, bc, ed);
      set_cfg(0, 0, 0, 1);   // R3 clamp of nibble 0
      do_word(16'h0081, 16'h00FE, 0, A_TXD, 0, cap, bc, ed);
      set_cfg(1, 1, 1, 0);   // R3 clamp of nibble 1
      do_word(16'h8001, 16'h7FFE, 0, A_TXD, 0, cap, bc, ed);
      set_cfg(5, 0, 1, 1);
      do_word(16'h12C6, 16'h3499, 0, A_TXD, 0, cap, bc, ed);

      // R3: bit 4 cleared has no effect on rate
      b_nib = 4; b_wide = 1; b_cpol = 0; b_cpha = 0;
      wr_reg(A_CFG, cfg_word(4, 1, 0, 0) & ~32'h10);
      do_word(16'hF00D, 16'h0BAD, 0, A_TXD, 0, cap, bc, ed);

      // R7: writing 1 keeps done, writing 0 clears it; R10 receive held
      rd_reg(A_RXD, keep);
      wr_reg(A_CAUSE, 32'h1);
      rd_reg(A_CAUSE, rv); chk("R7 done kept by write of one", rv, 32'h1);
      wr_reg(A_CAUSE, 32'h0);
      rd_reg(A_CAUSE, rv); chk("R7 done cleared by write of zero", rv, 32'h0);
      rd_reg(A_RXD, rv);   chk("R10 receive held after clear", rv, keep);

      // R8: transmit write during a word is ignored
      set_cfg(2, 0, 0, 0);
      do_word(16'h0069, 16'h0096, 1, A_TXD, 32'h0000_FF3C, cap, bc, ed);
      chk("R8 word unchanged by busy write", {24'h0, cap[7:0]}, 32'h69);
      chk("R8 length unchanged by busy write", bc, 32);
      rd_reg(A_CAUSE, rv); chk("R8 no second word started", rv, 32'h1);

      // R9: configuration change mid-word affects only the next word
      set_cfg(2, 0, 0, 0);
      do_word(16'h00C3, 16'h005A, 1, A_CFG, cfg_word(6, 1, 0, 0), cap, bc, ed);
      chk("R9 length kept from start", ed, 16);
      chk("R9 busy kept from start", bc, 32);
      b_nib = 6; b_wide = 1;
      do_word(16'hA55A, 16'h1234, 0, A_TXD, 0, cap, bc, ed);
      chk("R9 new setting on next word", ed, 32);

      // Random words, fixed seed
      for (int i = 0; i < 24; i++) begin
         set_cfg($urandom % 8, ($urandom % 2) == 1, ($urandom % 2) == 1, ($urandom % 2) == 1);
         if ((i % 6) == 5) set_cs(!b_cs);
         tx  = 16'($urandom);
         slv = 16'($urandom);
         do_word(tx, slv, 0, A_TXD, 0, cap, bc, ed);
      end

      set_cs(0);
      chk("R2 select released", {31'h0, cs_n}, 32'h1);

      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule